// File: doc/BRIEF.md
# Generational Write-Barrier Checker

This block supports a garbage collector that divides the heap into generations, from youngest to oldest. It holds two to four generation region registers. Each register describes one naturally aligned power-of-two range of the virtual address space. Software loads these registers through a small configuration write port.

For each proposed pointer store, the block is given the value about to be stored and the destination address. It decides whether the store would make a location outside a generation, or outside any younger generation, point into that generation. Those are the stores whose pointers the collector must record as roots. A value that lands in generation k is flagged when the destination lies in none of the generations 0 through k.

A request carries a mode. In check mode the decision is returned as a 0/1 result, for use by a test instruction or a conditional branch. In checked-store mode the same decision is returned instead as an exception request. The answer appears one clock cycle after the request.

Top module: `gc_write_barrier`

## Requirements
- R1: After synchronous reset, every generation register is disabled, and `res_valid`, `res_flag` and `exc_req` are 0.
- R2: Region register encoding:
  - Bit 0 enables the generation. Bits 10:1 are ignored.
  - In bits [VA_W-1:11], the lowest set bit, at position q, marks a region of 2^(q+1) bytes. Address bits above q must equal the stored bits for an address to match.
  - The smallest region is 4 KiB, with the marker at bit 11.
  - When bits [VA_W-1:11] are all zero, the generation never matches.
- R3: When the stored value lies in generation 0 and the destination does not, the store is flagged.
- R4: When the stored value lies in generation 1 and the destination lies in neither generation 0 nor generation 1, the store is flagged.
- R5: For every generation k, a value in generation k is flagged when the destination is in none of generations 0..k. No other store is flagged.
- R6: A disabled generation matches neither the value nor the address. With all generations disabled, nothing is flagged.
- R7: In check mode (`req_mode`=0), `res_flag` carries the decision one cycle after the request, and `exc_req` stays 0.
- R8: In checked-store mode (`req_mode`=1), `exc_req` carries the decision one cycle after the request, and `res_flag` stays 0.
- R9: `res_valid` is high exactly in the cycle after a cycle with `req_valid` high. Without a request, all three outputs are 0.
- R10: A write with `cfg_we` high loads `cfg_wdata` into register `cfg_idx`. The new value is used for requests issued from the next cycle on. A write to an index of NUM_GEN or above changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Generation register write enable |
| cfg_idx | input | IDX_W | Generation register index (0 = youngest) |
| cfg_wdata | input | VA_W | Encoded region and enable bit |
| req_valid | input | 1 | Check request present |
| req_mode | input | 1 | 0 = check result, 1 = checked store (exception) |
| req_value | input | VA_W | Pointer value to be stored |
| req_addr | input | VA_W | Destination address of the store |
| res_valid | output | 1 | Result of the previous cycle's request |
| res_flag | output | 1 | Barrier hit, check mode |
| exc_req | output | 1 | Exception request, checked-store mode |

## Verification
The bench uses three generations of 16-bit addresses. It sweeps every combination of 16 value pages and 16 destination pages, in both modes, against several region layouts:
- Nested sizes from 4 KiB to 32 KiB with junk in the ignored bits, which separates the generation 0 rule from the generation 1 and generation 2 rules.
- A middle generation switched off, which shows whether disabled regions leak into either the value side or the address side.
- A valid register with no size marker.
- All generations cleared.

An idle cycle and a write to an out-of-range index show that nothing is produced, or disturbed, outside a request.

// File: rtl/gcwb_pkg.sv
package gcwb_pkg;

    // Request mode: plain check result or checked store raising an exception
    typedef enum logic {
        GCWB_CHECK = 1'b0,
        GCWB_STORE = 1'b1
    } gcwb_mode_e;

    // Lowest bit of the size/address field in a region register (4 KiB minimum)
    localparam int GCWB_FIELD_LSB = 11;

    // Registered response
    typedef struct packed {
        logic valid;
        logic flag;
        logic exc;
    } gcwb_resp_t;

endpackage

// File: rtl/gcwb_gen_regs.sv
module gcwb_gen_regs
    import gcwb_pkg::*;
#(
    parameter int NUM_GEN = 4,
    parameter int VA_W    = 64,
    parameter int IDX_W   = 2,
    localparam int FW     = VA_W - GCWB_FIELD_LSB
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  logic [IDX_W-1:0]              idx,
    input  logic [VA_W-1:0]               wdata,
    output logic [NUM_GEN-1:0]            gen_en,
    output logic [NUM_GEN-1:0][FW-1:0]    gen_field
);

    // Bits 10:1 carry no meaning and are not stored
    logic unused_rsvd;
    assign unused_rsvd = ^wdata[GCWB_FIELD_LSB-1:1];

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                gen_en[g]    <= 1'b0;
                gen_field[g] <= '0;
            end else if (we && idx == IDX_W'(g)) begin
                gen_en[g]    <= wdata[0];
                gen_field[g] <= wdata[VA_W-1:GCWB_FIELD_LSB];
            end
        end

        // R10: a register changes only through a write addressed to it
        p_write_only_r10: assert property (@(posedge clk) disable iff (rst)
            !(we && idx == IDX_W'(g)) |=> $stable(gen_field[g]) && $stable(gen_en[g]));
    end

endmodule

// File: rtl/gcwb_region_match.sv
module gcwb_region_match
    import gcwb_pkg::*;
#(
    parameter int VA_W = 64,
    localparam int FW  = VA_W - GCWB_FIELD_LSB
) (
    input  logic          en,
    input  logic [FW-1:0] field,
    input  logic [FW-1:0] va_hi,
    output logic          hit
);

    logic [FW-1:0] marker;
    logic [FW-1:0] care;

    always_comb begin
        marker = field & (~field + FW'(1));     // lowest set bit = size marker
        care   = ~(marker | (marker - FW'(1))); // bits strictly above the marker
        hit    = en && (field != '0) && (((va_hi ^ field) & care) == '0);
    end

endmodule

// File: rtl/gcwb_barrier_eval.sv
module gcwb_barrier_eval
    import gcwb_pkg::*;
#(
    parameter int NUM_GEN = 4,
    parameter int VA_W    = 64,
    localparam int FW     = VA_W - GCWB_FIELD_LSB
) (
    input  logic [NUM_GEN-1:0]         gen_en,
    input  logic [NUM_GEN-1:0][FW-1:0] gen_field,
    input  logic [FW-1:0]              value_hi,
    input  logic [FW-1:0]              addr_hi,
    output logic                       flag
);

    logic [NUM_GEN-1:0] val_hit;
    logic [NUM_GEN-1:0] adr_hit;
    logic [NUM_GEN-1:0] adr_young;   // address lies in generation 0..k

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_match
        gcwb_region_match #(.VA_W(VA_W)) u_val (
            .en(gen_en[g]), .field(gen_field[g]), .va_hi(value_hi), .hit(val_hit[g]));
        gcwb_region_match #(.VA_W(VA_W)) u_adr (
            .en(gen_en[g]), .field(gen_field[g]), .va_hi(addr_hi), .hit(adr_hit[g]));
    end

    always_comb begin
        adr_young[0] = adr_hit[0];
        for (int k = 1; k < NUM_GEN; k++) begin
            adr_young[k] = adr_young[k-1] | adr_hit[k];
        end
        flag = 1'b0;
        for (int k = 0; k < NUM_GEN; k++) begin
            flag = flag | (val_hit[k] & ~adr_young[k]);   // R5
        end
    end

    // R6: a disabled generation produces no match on either side
    always_comb begin
        a_dis_nomatch_r6: assert (((val_hit | adr_hit) & ~gen_en) == '0);
    end

endmodule

// File: rtl/gc_write_barrier.sv
module gc_write_barrier
    import gcwb_pkg::*;
#(
    parameter int NUM_GEN  = 4,
    parameter int VA_W     = 64,
    localparam int IDX_W   = (NUM_GEN > 2) ? 2 : 1,
    localparam int FW      = VA_W - GCWB_FIELD_LSB
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [VA_W-1:0]   cfg_wdata,
    input  logic              req_valid,
    input  logic              req_mode,
    input  logic [VA_W-1:0]   req_value,
    input  logic [VA_W-1:0]   req_addr,
    output logic              res_valid,
    output logic              res_flag,
    output logic              exc_req
);

    logic [NUM_GEN-1:0]         gen_en;
    logic [NUM_GEN-1:0][FW-1:0] gen_field;
    logic                       hit_now;
    gcwb_resp_t                 resp_q;
    gcwb_mode_e                 mode;

    // Page offsets never take part in matching
    logic unused_offsets;
    assign unused_offsets = ^{req_value[GCWB_FIELD_LSB-1:0], req_addr[GCWB_FIELD_LSB-1:0]};

    assign mode = gcwb_mode_e'(req_mode);

    gcwb_gen_regs #(.NUM_GEN(NUM_GEN), .VA_W(VA_W), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .idx(cfg_idx), .wdata(cfg_wdata),
        .gen_en(gen_en), .gen_field(gen_field));

    gcwb_barrier_eval #(.NUM_GEN(NUM_GEN), .VA_W(VA_W)) u_eval (
        .gen_en(gen_en), .gen_field(gen_field),
        .value_hi(req_value[VA_W-1:GCWB_FIELD_LSB]),
        .addr_hi(req_addr[VA_W-1:GCWB_FIELD_LSB]),
        .flag(hit_now));

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_q <= '0;
        end else begin
            resp_q.valid <= req_valid;
            resp_q.flag  <= req_valid && (mode == GCWB_CHECK) && hit_now;
            resp_q.exc   <= req_valid && (mode == GCWB_STORE) && hit_now;
        end
    end

    assign res_valid = resp_q.valid;
    assign res_flag  = resp_q.flag;
    assign exc_req   = resp_q.exc;

    // R1: outputs are quiet right after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> !res_valid && !res_flag && !exc_req);

    // R9: response follows request by one cycle, silence otherwise
    p_resp_lat_r9: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> res_valid);
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !res_valid && !res_flag && !exc_req);

    // R7: a check result only comes from a check-mode request
    p_flag_mode_r7: assert property (@(posedge clk) disable iff (rst)
        res_flag |-> $past(req_mode) == 1'b0);

    // R8: an exception only comes from a checked-store request
    p_exc_mode_r8: assert property (@(posedge clk) disable iff (rst)
        exc_req |-> $past(req_mode) == 1'b1 && !res_flag);

    // R6: with every generation disabled nothing is flagged
    p_none_enabled_r6: assert property (@(posedge clk) disable iff (rst)
        (gen_en == '0) |=> !res_flag && !exc_req);

endmodule

// File: tb/gc_write_barrier_test.sv
`timescale 1ns/1ps
module gc_write_barrier_test;

    localparam int NG = 3;
    localparam int VW = 16;

    logic clk = 1'b0;
    logic rst;
    logic cfg_we;
    logic [1:0] cfg_idx;
    logic [VW-1:0] cfg_wdata;
    logic req_valid, req_mode;
    logic [VW-1:0] req_value, req_addr;
    logic res_valid, res_flag, exc_req;

    int checks = 0;
    int errors = 0;

    // Bench model of the regions: base, size exponent, live flag
    int m_base [NG];
    int m_size [NG];
    bit m_live [NG];

    always #2.5 clk = ~clk;

    gc_write_barrier #(.NUM_GEN(NG), .VA_W(VW)) uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_mode(req_mode), .req_value(req_value), .req_addr(req_addr),
        .res_valid(res_valid), .res_flag(res_flag), .exc_req(exc_req));

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_up();
    end

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {valid,flag,exc} actual %b expected %b", req, act, exp);
        end
    endtask

    // Program generation k: base aligned to 2^sz, enable en, junk in bits 10:1 (R2)
    task automatic set_gen(input int k, input int base, input int sz, input bit en,
                           input bit marker, input int junk);
        int enc;
        enc = ((base >> sz) << sz) | (marker ? (1 << (sz - 1)) : 0) | (junk & 16'h07FE) | int'(en);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 2'(k); cfg_wdata = VW'(enc);
        @(negedge clk);
        cfg_we = 1'b0;
        m_base[k] = base; m_size[k] = sz; m_live[k] = en && marker;
    endtask

    function automatic bit in_gen(input int x, input int k);
        return m_live[k] && ((x >> m_size[k]) == (m_base[k] >> m_size[k]));
    endfunction

    function automatic bit expect_hit(input int v, input int a);
        bit young = 1'b0;
        bit hit = 1'b0;
        for (int k = 0; k < NG; k++) begin
            young = young | in_gen(a, k);
            if (in_gen(v, k) && !young) hit = 1'b1;
        end
        return hit;
    endfunction

    // Sweep 16 value pages x 16 address pages in both modes.
    // Tags: R3 R4 R5 (decision), R7 (mode 0), R8 (mode 1).
    task automatic sweep(input string tag);
        for (int m = 0; m < 2; m++) begin
            for (int vp = 0; vp < 16; vp++) begin
                for (int ap = 0; ap < 16; ap++) begin
                    int v, a;
                    bit e;
                    v = (vp << 12) | ((vp * 37 + ap * 11) & 12'hFFF);
                    a = (ap << 12) | ((ap * 53 + vp * 7) & 12'hFFF);
                    e = expect_hit(v, a);
                    @(negedge clk);
                    req_valid = 1'b1; req_mode = m[0];
                    req_value = VW'(v); req_addr = VW'(a);
                    @(negedge clk);
                    req_valid = 1'b0;
                    if (m == 0) check({tag, " R7"}, {res_valid, res_flag, exc_req}, {1'b1, e, 1'b0});
                    else        check({tag, " R8"}, {res_valid, res_flag, exc_req}, {1'b1, 1'b0, e});
                end
            end
        end
    endtask

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_idx = '0; cfg_wdata = '0;
        req_valid = 1'b0; req_mode = 1'b0; req_value = '0; req_addr = '0;
        for (int k = 0; k < NG; k++) begin m_base[k] = 0; m_size[k] = 12; m_live[k] = 1'b0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset outputs", {res_valid, res_flag, exc_req}, 3'b000);

        // R1/R6: after reset every generation is off, so nothing is flagged
        @(negedge clk);
        req_valid = 1'b1; req_mode = 1'b0; req_value = 16'h0123; req_addr = 16'hF000;
        @(negedge clk);
        req_valid = 1'b0;
        check("R1 disabled after reset", {res_valid, res_flag, exc_req}, 3'b100);
        @(negedge clk);
        check("R9 idle cycle", {res_valid, res_flag, exc_req}, 3'b000);

        // Layout A: gen0 4 KiB, gen1 16 KiB, gen2 32 KiB; ignored bits set (R2, R3, R4, R5)
        set_gen(0, 16'h1000, 12, 1'b1, 1'b1, 16'h0000);
        set_gen(1, 16'h4000, 14, 1'b1, 1'b1, 16'h05AA);
        set_gen(2, 16'h8000, 15, 1'b1, 1'b1, 16'h07FE);
        // R10: a write to index 3 (beyond NUM_GEN) must change nothing
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 2'd3; cfg_wdata = 16'h0801;
        @(negedge clk);
        cfg_we = 1'b0;
        sweep("R2 R3 R4 R5 R10 layout A");

        // Layout B: gen1 disabled (R6)
        set_gen(1, 16'h4000, 14, 1'b0, 1'b1, 16'h0000);
        sweep("R6 R5 layout B");

        // Layout C: gen0 8 KiB at 0x2000, gen1 4 KiB at 0xF000, gen2 valid without marker (R2)
        set_gen(0, 16'h2000, 13, 1'b1, 1'b1, 16'h0000);
        set_gen(1, 16'hF000, 12, 1'b1, 1'b1, 16'h0000);
        set_gen(2, 16'h0000, 15, 1'b1, 1'b0, 16'h0000);
        sweep("R2 R4 layout C");

        // Layout D: all cleared (R6)
        for (int k = 0; k < NG; k++) set_gen(k, 0, 12, 1'b0, 1'b0, 0);
        sweep("R6 layout D");

        @(negedge clk);
        check("R9 idle at end", {res_valid, res_flag, exc_req}, 3'b000);
        finish_up();
    end

endmodule